// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block serialises bytes (or 9-bit words) onto an asynchronous transmit line. A one-word holding buffer sits in front of the shift register. Software can therefore queue the next word while the current frame is still going out, and consecutive frames leave with no idle time between them. A built-in bit-rate divider sets the bit period from an 8-bit divisor and a fast/slow prescale select.

Software drives three write ports: data, control and divisor. It watches two flags: "buffer empty" and "shifter empty". An interrupt request mirrors the buffer-empty flag when it is enabled. Clearing the enable bit aborts any frame in progress, drops the queued word and holds the line idle.

Top module: `uart_dbuf_tx`

## Requirements
- R1: A frame is a start bit (0), the data bits least significant first, then a stop bit (1). The tx line rests at 1 whenever no frame is shifting.
- R2: Control bit 1 selects 9-bit frames. Control bit 2 supplies the ninth data bit, which is sampled when the word enters the shifter and sent after data bit 7. With control bit 1 low, frames carry 8 data bits.
- R3: A data write, accepted only while control bit 0 (enable) is 1, clears `buf_empty` on the next cycle. If the shifter is idle, the word moves into it one cycle later: `buf_empty` returns to 1 and the start bit appears on tx in that same cycle.
- R4: `shift_empty` is 1 when idle and 0 from the start bit to the end of the stop bit. It returns to 1 exactly (bits per frame × bit period) cycles after the transfer, provided nothing is queued.
- R5: A word queued before the current stop bit ends starts its start bit in the very next cycle. Frame starts are therefore spaced by exactly one frame length.
- R6: Every bit lasts (divisor+1)×16 clocks when control bit 3 (fast) is 1, and (divisor+1)×64 clocks when it is 0.
- R7: After reset, tx=1, `buf_empty`=1, `shift_empty`=1, `irq`=0, the divisor is 0 and all control bits are 0. Data writes are therefore ignored until enable is set.
- R8: `irq` equals `buf_empty` AND control bit 4 (interrupt enable).
- R9: While enable is 0, data writes are ignored, any frame in progress is abandoned, tx is 1, and both empty flags are 1.
- R10: A data write while the buffer is still full replaces the queued word. Only the last word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_we | input | 1 | Data write strobe |
| data_in | input | 8 | Word to queue |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_in | input | 5 | {irq enable, fast, ninth bit, 9-bit mode, enable} |
| div_we | input | 1 | Divisor write strobe |
| div_in | input | 8 | Bit-period divisor |
| tx | output | 1 | Serial output, idle high |
| buf_empty | output | 1 | Holding buffer empty |
| shift_empty | output | 1 | Shift register empty |
| irq | output | 1 | Transmit interrupt request |

## Verification
A wrong transfer or a stale buffer flag shows up within two cycles of a data write, as a late start bit or a `buf_empty`/`irq` level that does not match. A bad bit counter or prescaler corrupts the decoded word or moves the `shift_empty` rising edge. That edge is checked to the exact cycle, so timing errors are caught at the end of the first frame. Lost back-to-back scheduling shows as a change in the spacing between frame starts. A leaked overwrite or disable shows as an extra decoded frame.

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx #(
  parameter int DIV_W     = 8,
  parameter int SLOW_PRE  = 64,
  parameter int FAST_PRE  = 16,
  localparam int PW = $clog2(SLOW_PRE > FAST_PRE ? SLOW_PRE : FAST_PRE) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_we,
  input  logic [7:0]       data_in,
  input  logic             ctrl_we,
  input  logic [4:0]       ctrl_in,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_in,
  output logic             tx,
  output logic             buf_empty,
  output logic             shift_empty,
  output logic             irq
);

  logic [4:0]       ctrl_r;
  logic [DIV_W-1:0] div_r, bc;
  logic [PW-1:0]    pc;
  logic [7:0]       hold;
  logic             hold_full, busy;
  logic [10:0]      sh;
  logic [3:0]       left;

  wire en    = ctrl_r[0];
  wire nine  = ctrl_r[1];
  wire b8    = ctrl_r[2];
  wire fast  = ctrl_r[3];
  wire ien   = ctrl_r[4];

  wire [PW-1:0] lim = fast ? PW'(FAST_PRE - 1) : PW'(SLOW_PRE - 1);
  wire tick      = pc >= lim;
  wire shift_now = busy && tick && (bc == '0);
  wire last      = left == 4'd1;
  wire load      = en && hold_full && (!busy || (shift_now && last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_r    <= '0;
      div_r     <= '0;
      bc        <= '0;
      pc        <= '0;
      hold      <= '0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      sh        <= '1;
      left      <= '0;
    end else begin
      if (ctrl_we) ctrl_r <= ctrl_in;
      if (div_we)  div_r  <= div_in;
      if (!en) begin
        hold_full <= 1'b0;
        busy      <= 1'b0;
      end else begin
        if (load) begin
          busy <= 1'b1;
          sh   <= nine ? {1'b1, b8, hold, 1'b0} : {2'b11, hold, 1'b0};
          left <= nine ? 4'd11 : 4'd10;
          pc   <= '0;
          bc   <= div_r;
        end else if (busy) begin
          if (tick) begin
            pc <= '0;
            if (bc == '0) begin
              bc   <= div_r;
              sh   <= {1'b1, sh[10:1]};
              left <= left - 4'd1;
              if (last) busy <= 1'b0;
            end else begin
              bc <= bc - 1'b1;
            end
          end else begin
            pc <= pc + 1'b1;
          end
        end
        if (data_we) begin
          hold      <= data_in;
          hold_full <= 1'b1;
        end else if (load) begin
          hold_full <= 1'b0;
        end
      end
    end
  end

  assign tx          = busy ? sh[0] : 1'b1;
  assign buf_empty   = !hold_full;
  assign shift_empty = !busy;
  assign irq         = buf_empty && ien;

  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx);

  p_write_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && en) |=> !buf_empty);

  p_transfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hold_full && !busy) |=> (busy && !tx));

  p_back_to_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hold_full && shift_now && last) |=> (busy && !tx));

  p_prescale_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pc < PW'(SLOW_PRE)));

  p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (buf_empty && shift_empty && tx));

endmodule

// File: tb/uart_dbuf_tx_tb_top.sv
`timescale 1ns/1ps
module uart_dbuf_tx_tb_top;
  logic clk = 0, rst_n = 0;
  logic data_we = 0, ctrl_we = 0, div_we = 0;
  logic [7:0] data_in = 0, div_in = 0;
  logic [4:0] ctrl_in = 0;
  logic tx, buf_empty, shift_empty, irq;

  uart_dbuf_tx dut_i (.clk(clk), .rst_n(rst_n), .data_we(data_we), .data_in(data_in),
    .ctrl_we(ctrl_we), .ctrl_in(ctrl_in), .div_we(div_we), .div_in(div_in),
    .tx(tx), .buf_empty(buf_empty), .shift_empty(shift_empty), .irq(irq));

  always #2.5 clk = ~clk;

  int nvec = 0, nerr = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // line monitor: decodes frames from tx, independent of the design
  int mon_P = 16, mon_n = 8;
  bit mon_clr = 0;
  int nfr = 0, ms = 0, mi = 0;
  bit mbusy = 0, mok = 1;
  logic [8:0] mw;
  logic [8:0] got_word [0:15];
  bit got_ok [0:15];
  int got_start [0:15];

  always @(negedge clk) begin
    if (mon_clr) begin
      mbusy = 0; nfr = 0;
    end else if (!mbusy) begin
      if (rst_n && tx === 1'b0) begin
        mbusy = 1; ms = cyc; mi = 0; mw = 0; mok = 1;
      end
    end else if (cyc == ms + mon_P/2 + mi*mon_P) begin
      if (mi == 0) begin
        if (tx !== 1'b0) mok = 0;
      end else if (mi <= mon_n) begin
        mw[mi-1] = tx;
      end else begin
        if (tx !== 1'b1) mok = 0;
        if (nfr < 16) begin
          got_word[nfr] = mw; got_ok[nfr] = mok; got_start[nfr] = ms;
        end
        nfr = nfr + 1; mbusy = 0;
      end
      mi = mi + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int period(input bit fast, input int dv);
    return (dv + 1) * (fast ? 16 : 64);
  endfunction
  function automatic int frame_bits(input bit nine);
    return nine ? 11 : 10;
  endfunction
  function automatic int exp_word(input logic [7:0] d, input bit nine, input bit b8);
    return nine ? {b8, d} : {1'b0, d};
  endfunction

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); data_we = 1; data_in = v;
    @(negedge clk); data_we = 0;
  endtask
  task automatic wr_ctrl(input logic [4:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_in = v;
    @(negedge clk); ctrl_we = 0;
  endtask
  task automatic wr_div(input logic [7:0] v);
    @(negedge clk); div_we = 1; div_in = v;
    @(negedge clk); div_we = 0;
  endtask
  task automatic mclear();
    @(negedge clk); mon_clr = 1;
    @(negedge clk); @(negedge clk); mon_clr = 0;
  endtask
  task automatic setmode(input bit nine, b8, fast, ien, input int dv);
    wr_div(dv[7:0]);
    wr_ctrl({ien, fast, b8, nine, 1'b1});
    mon_P = period(fast, dv); mon_n = nine ? 9 : 8;
    mclear();
  endtask
  task automatic wait_frames(input int n);
    int t = 0;
    while (nfr < n && t < 20000) begin @(negedge clk); t++; end
  endtask
  task automatic wait_idle();
    int t = 0;
    while (!(shift_empty && buf_empty) && t < 20000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int c0, P;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R7 reset tx", tx, 1);
    chk("R7 reset buf_empty", buf_empty, 1);
    chk("R7 reset shift_empty", shift_empty, 1);
    chk("R7 reset irq", irq, 0);
    rst_n = 1;
    @(negedge clk);
    // R7/R9: enable is 0 after reset, so a data write is ignored
    wr_data(8'h55);
    repeat (40) @(negedge clk);
    chk("R9 write ignored frames", nfr, 0);
    chk("R9 write ignored buf_empty", buf_empty, 1);
    chk("R9 idle tx", tx, 1);

    // R7 divisor resets to 0: fast mode gives 16-clock bits without a divisor write
    wr_ctrl(5'b01001); mon_P = 16; mon_n = 8; mclear();
    wr_data(8'hA5); c0 = cyc;
    chk("R3 buf full after write", buf_empty, 0);
    @(negedge clk);
    chk("R3 buf empty after transfer", buf_empty, 1);
    chk("R4 shifter busy", shift_empty, 0);
    chk("R1 start bit", tx, 0);
    while (cyc < c0 + 10*16) @(negedge clk);
    chk("R4 still busy last cycle", shift_empty, 0);
    @(negedge clk);
    chk("R4 empty at frame end", shift_empty, 1);
    wait_frames(1);
    chk("R1 R7 word", got_word[0], 9'h0A5);
    chk("R1 frame bits", got_ok[0], 1);
    chk("R3 start cycle", got_start[0], c0 + 1);

    // R8 interrupt gating
    wr_ctrl(5'b11001);
    @(negedge clk);
    chk("R8 irq on when empty", irq, 1);
    @(negedge clk); data_we = 1; data_in = 8'h0F;
    @(negedge clk); data_we = 0;
    chk("R8 irq low while full", irq, 0);
    @(negedge clk);
    chk("R8 irq back after transfer", irq, 1);
    wait_idle();
    wr_ctrl(5'b01001);
    @(negedge clk);
    chk("R8 irq off when disabled", irq, 0);

    // R2 nine-bit frames
    setmode(1, 1, 1, 0, 0);
    wr_data(8'h3C); wait_frames(1);
    chk("R2 ninth bit 1", got_word[0], 9'h13C);
    wait_idle();
    setmode(1, 0, 1, 0, 1);
    wr_data(8'hC3); wait_frames(1);
    chk("R2 ninth bit 0", got_word[0], 9'h0C3);
    wait_idle();

    // R6 slow mode exact frame length
    setmode(0, 0, 0, 0, 1);
    P = period(0, 1);
    wr_data(8'h81); c0 = cyc;
    while (cyc < c0 + 10*P) @(negedge clk);
    chk("R6 slow busy at end", shift_empty, 0);
    @(negedge clk);
    chk("R6 slow frame length", shift_empty, 1);
    wait_frames(1);
    chk("R6 slow word", got_word[0], 9'h081);
    wait_idle();

    // R5 back-to-back
    setmode(0, 0, 1, 0, 2);
    P = period(1, 2);
    wr_data(8'h11); repeat (5) @(negedge clk); wr_data(8'h22);
    wait_frames(2);
    chk("R5 first word", got_word[0], 9'h011);
    chk("R5 second word", got_word[1], 9'h022);
    chk("R5 no gap", got_start[1] - got_start[0], 10*P);
    wait_idle();

    // R10 overwrite of the queued word
    setmode(0, 0, 1, 0, 0);
    wr_data(8'hAA); repeat (3) @(negedge clk);
    wr_data(8'hBB); wr_data(8'hCC);
    wait_frames(2); repeat (400) @(negedge clk);
    chk("R10 frame count", nfr, 2);
    chk("R10 first word", got_word[0], 9'h0AA);
    chk("R10 last write wins", got_word[1], 9'h0CC);
    wait_idle();

    // R9 disable mid-frame
    setmode(0, 0, 1, 0, 3);
    wr_data(8'h00); repeat (3) @(negedge clk); wr_data(8'hFF);
    repeat (30) @(negedge clk);
    wr_ctrl(5'b01000);
    @(negedge clk);
    chk("R9 tx idle", tx, 1);
    chk("R9 shifter empty", shift_empty, 1);
    chk("R9 buffer dropped", buf_empty, 1);
    mclear();
    wr_ctrl(5'b01001);
    repeat (2000) @(negedge clk);
    chk("R9 no leftover frame", nfr, 0);

    // random frames, some queued back-to-back
    for (int it = 0; it < 24; it++) begin
      bit fast, nine, b8, pair;
      int dv, dly;
      logic [7:0] d0, d1;
      fast = ($urandom % 4) != 0; nine = $urandom % 2; b8 = $urandom % 2;
      dv = $urandom % 3; pair = $urandom % 2;
      d0 = $urandom; d1 = $urandom;
      setmode(nine, b8, fast, 0, dv);
      P = period(fast, dv);
      wr_data(d0);
      if (pair) begin
        dly = 1 + ($urandom % (3*P));
        repeat (dly) @(negedge clk);
        wr_data(d1);
      end
      wait_frames(pair ? 2 : 1);
      chk("R1 R2 random word", got_word[0], exp_word(d0, nine, b8));
      chk("R1 random framing", got_ok[0], 1);
      if (pair) begin
        chk("R5 random second word", got_word[1], exp_word(d1, nine, b8));
        chk("R5 random spacing", got_start[1] - got_start[0], frame_bits(nine)*P);
      end
      wait_idle();
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nvec++; nerr++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule